// File: doc/BRIEF.md
# Display Controller Interrupt Register Block

This block gathers the event pulses of a raster display pipeline into one level interrupt line and exposes them to software through a small register port. Five pipeline events each arrive as a one-cycle pulse: end of frame on either of two frame buffers, FIFO underflow, loss of sync, and completion of a palette load. Each event sets a sticky bit in a raw status word. An enable mask selects which of these bits can reach the interrupt line.

Software changes the mask only through two dedicated registers, one that sets the bits written as one and one that clears them, so no read-modify-write of the mask is ever needed. Software reads the raw status or the masked status. It clears events by writing ones to the masked status offset, usually writing back the value it read. After the line has been raised and the pending events have gone away, the line stays low until software writes to the end-of-interrupt register. That write re-arms the line, so events still pending raise it again at once.

The block also holds a fixed identification word and three clock-enable bits that drive the pipeline's clock gates. Register access uses single-cycle writes and reads with one cycle of latency.

Top module: `disp_irq_regs`

## Requirements
- R1: After reset the raw status, enable mask, clock enables and read data are zero, the interrupt line is low and the line is armed.
- R2: An event pulse sets its raw status bit (byte offset 0x58) on the next clock edge. The bit stays set until software clears it. Bit positions are sync lost 2, underflow 5, palette load done 6, end of frame buffer 0 bit 8, and end of frame buffer 1 bit 9. All other status bits read zero.
- R3: A write to offset 0x5C clears every raw status bit whose write-data bit is one and leaves the rest. A write to offset 0x58 has no effect.
- R4: When an event pulse and a clear write hit the same status bit in the same cycle, the bit stays set.
- R5: A write to offset 0x60 sets the mask bits written as one, and a write to offset 0x64 clears them. Bits written as zero keep their value, so writing zero to 0x60 changes nothing. Reads of 0x60 and 0x64 both return the mask. Only the five event bit positions of R2 can be set.
- R6: A read of offset 0x5C returns raw status AND enable mask.
- R7: While armed, irq_o is high exactly when the masked status is nonzero. It is a level that holds as long as masked bits are pending.
- R8: Once irq_o has been high and the masked status has then dropped to zero, the line is disarmed. irq_o stays low, even for new pending events, until any write to offset 0x68 re-arms it. After that write, events still pending raise irq_o again.
- R9: Offset 0x00 reads the identification value given by a parameter (default 0x4F200800). Writes to it are ignored.
- R10: Offset 0x6C holds three read/write clock enables: core at bit 0, secondary interface at bit 1, DMA at bit 2. They drive clk_en_o directly. Its upper bits read zero.
- R11: A read issued in one cycle returns its data on reg_rdata_o after the next clock edge. Offsets not listed in R2 to R10 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_eof0_i | input | 1 | End-of-frame pulse, buffer 0 |
| ev_eof1_i | input | 1 | End-of-frame pulse, buffer 1 |
| ev_underflow_i | input | 1 | FIFO underflow pulse |
| ev_sync_lost_i | input | 1 | Sync lost pulse |
| ev_pal_done_i | input | 1 | Palette load done pulse |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the read |
| irq_o | output | 1 | Level interrupt line |
| clk_en_o | output | 3 | Clock enables {dma, secondary, core} |

## Verification
On every cycle the assertions check these properties: the line is never high without a masked pending bit, every event pulse is latched, no status bit drops without a clear write, the mask and clock enables move only on writes to their own offsets, and re-arming happens only through an end-of-interrupt write. Only the bench's scenarios can show the exact register encodings and read values. The same holds for the set/clear arithmetic on the mask and for the disarm-then-rearm sequence with an event arriving while disarmed. The bench scenarios also cover the event-beats-clear collision and the ignored writes to read-only and undefined offsets.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int STAT_W = 10;
  localparam int CLK_W  = 3;

  localparam int B_SYNC  = 2;
  localparam int B_UFLOW = 5;
  localparam int B_PAL   = 6;
  localparam int B_EOF0  = 8;
  localparam int B_EOF1  = 9;

  localparam logic [STAT_W-1:0] IMPL_MASK =
    STAT_W'((1 << B_SYNC) | (1 << B_UFLOW) | (1 << B_PAL) | (1 << B_EOF0) | (1 << B_EOF1));

  typedef enum logic [ADDR_W-1:0] {
    OFS_ID     = 8'h00,
    OFS_RAW    = 8'h58,
    OFS_MSK    = 8'h5C,
    OFS_EN_SET = 8'h60,
    OFS_EN_CLR = 8'h64,
    OFS_EOI    = 8'h68,
    OFS_CLK    = 8'h6C
  } reg_ofs_e;
endpackage

// File: rtl/disp_irq_status.sv
module disp_irq_status
  import disp_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] ev_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] raw_o
);
  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_impl
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= ev_i[b] | (bit_q & ~clr_i[b]); // event beats clear
      end
      assign raw_o[b] = bit_q;
    end else begin : g_none
      assign raw_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/disp_irq_mask.sv
module disp_irq_mask
  import disp_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [STAT_W-1:0] bits_i,
  output logic [STAT_W-1:0] mask_o
);
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] sel;

  assign sel = bits_i & IMPL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (set_i) mask_q <= mask_q | sel;
    else if (clr_i) mask_q <= mask_q & ~sel;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/disp_irq_line.sv
module disp_irq_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic eoi_i,
  output logic irq_o,
  output logic armed_o
);
  logic armed_q;
  logic seen_q;

  assign irq_o = armed_q & pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      seen_q  <= 1'b0;
    end else if (eoi_i) begin
      armed_q <= 1'b1;
      seen_q  <= 1'b0;
    end else begin
      if (irq_o) seen_q <= 1'b1;
      // line has fired and drained: hold off until end-of-interrupt
      if (seen_q && !pend_i) armed_q <= 1'b0;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/disp_irq_regs.sv
module disp_irq_regs
  import disp_irq_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h4F20_0800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_eof0_i,
  input  logic              ev_eof1_i,
  input  logic              ev_underflow_i,
  input  logic              ev_sync_lost_i,
  input  logic              ev_pal_done_i,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic [CLK_W-1:0]  clk_en_o
);
  logic [STAT_W-1:0] ev_vec;
  logic [STAT_W-1:0] raw_q;
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] masked;
  logic [STAT_W-1:0] stat_clr;
  logic [CLK_W-1:0]  clk_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              wr, rd;
  logic              wr_msk, wr_set, wr_clr, wr_eoi, wr_clk;
  logic              armed;

  always_comb begin
    ev_vec          = '0;
    ev_vec[B_SYNC]  = ev_sync_lost_i;
    ev_vec[B_UFLOW] = ev_underflow_i;
    ev_vec[B_PAL]   = ev_pal_done_i;
    ev_vec[B_EOF0]  = ev_eof0_i;
    ev_vec[B_EOF1]  = ev_eof1_i;
  end

  assign wr     = reg_valid_i &  reg_write_i;
  assign rd     = reg_valid_i & ~reg_write_i;
  assign wr_msk = wr && (reg_addr_i == OFS_MSK);
  assign wr_set = wr && (reg_addr_i == OFS_EN_SET);
  assign wr_clr = wr && (reg_addr_i == OFS_EN_CLR);
  assign wr_eoi = wr && (reg_addr_i == OFS_EOI);
  assign wr_clk = wr && (reg_addr_i == OFS_CLK);

  assign stat_clr = wr_msk ? reg_wdata_i[STAT_W-1:0] : '0;

  disp_irq_status u_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ev_i  (ev_vec),
    .clr_i (stat_clr),
    .raw_o (raw_q)
  );

  disp_irq_mask u_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (wr_set),
    .clr_i (wr_clr),
    .bits_i(reg_wdata_i[STAT_W-1:0]),
    .mask_o(mask_q)
  );

  assign masked = raw_q & mask_q;

  disp_irq_line u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (|masked),
    .eoi_i  (wr_eoi),
    .irq_o  (irq_o),
    .armed_o(armed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     clk_q <= '0;
    else if (wr_clk) clk_q <= reg_wdata_i[CLK_W-1:0];
  end
  assign clk_en_o = clk_q;

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr_i)
      OFS_ID:                 rd_mux = ID_VALUE;
      OFS_RAW:                rd_mux = DATA_W'(raw_q);
      OFS_MSK:                rd_mux = DATA_W'(masked);
      OFS_EN_SET, OFS_EN_CLR: rd_mux = DATA_W'(mask_q);
      OFS_CLK:                rd_mux = DATA_W'(clk_q);
      default:                rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end
  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/disp_irq_regs_chk.sv
module disp_irq_regs_chk
  import disp_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STAT_W-1:0] ev_i,
  input logic [STAT_W-1:0] raw_i,
  input logic [STAT_W-1:0] mask_i,
  input logic              irq_i,
  input logic              armed_i,
  input logic              wr_msk_i,
  input logic              wr_set_i,
  input logic              wr_clr_i,
  input logic              wr_eoi_i,
  input logic              wr_clk_i,
  input logic [CLK_W-1:0]  clk_en_i
);
  assert_irq_needs_pend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (|(raw_i & mask_i)));

  assert_event_latched_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ev_i & IMPL_MASK)) |=> ((raw_i & $past(ev_i) & IMPL_MASK) == ($past(ev_i) & IMPL_MASK)));

  assert_no_silent_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_msk_i |=> ((raw_i & $past(raw_i)) == $past(raw_i)));

  assert_mask_only_by_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_set_i || wr_clr_i) |=> $stable(mask_i));

  assert_rearm_by_eoi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_i) |-> $past(wr_eoi_i));

  assert_clk_en_by_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_clk_i |=> $stable(clk_en_i));
endmodule

bind disp_irq_regs disp_irq_regs_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ev_i    (ev_vec),
  .raw_i   (raw_q),
  .mask_i  (mask_q),
  .irq_i   (irq_o),
  .armed_i (armed),
  .wr_msk_i(wr_msk),
  .wr_set_i(wr_set),
  .wr_clr_i(wr_clr),
  .wr_eoi_i(wr_eoi),
  .wr_clk_i(wr_clk),
  .clk_en_i(clk_en_o)
);

// File: tb/disp_irq_regs_tb_top.sv
module disp_irq_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_eof0 = 0, ev_eof1 = 0, ev_uf = 0, ev_sync = 0, ev_pal = 0;
  logic        valid = 0, write = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [2:0]  clk_en;

  int total = 0;
  int bad = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #4 clk = ~clk;

  disp_irq_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ev_eof0_i(ev_eof0), .ev_eof1_i(ev_eof1), .ev_underflow_i(ev_uf),
    .ev_sync_lost_i(ev_sync), .ev_pal_done_i(ev_pal),
    .reg_valid_i(valid), .reg_write_i(write), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .clk_en_o(clk_en)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data one cycle after each read
  always @(posedge clk) rd_seen <= valid & ~write;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check(32'hDEAD, 32'h0, "R11 unexpected read");
      else check(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    valid = 1; write = 0; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    valid = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1; write = 1; addr = a; wdata = d;
    @(negedge clk);
    valid = 0; write = 0;
  endtask

  task automatic pulse(input logic s, input logic u, input logic p, input logic e0, input logic e1);
    @(negedge clk);
    ev_sync = s; ev_uf = u; ev_pal = p; ev_eof0 = e0; ev_eof1 = e1;
    @(negedge clk);
    {ev_sync, ev_uf, ev_pal, ev_eof0, ev_eof1} = '0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    check({31'b0, irq}, {31'b0, e}, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({31'b0, irq}, 32'h0, "R1 irq in reset");
    rst_n = 1'b1;
    check({29'b0, clk_en}, 32'h0, "R1 clk_en reset");
    check(rdata, 32'h0, "R1 rdata reset");
    rd(8'h58, 32'h0, "R1 raw reset");
    rd(8'h60, 32'h0, "R1 mask reset");
    rd(8'h00, 32'h4F20_0800, "R9 id");

    wr(8'h60, 32'h0);
    rd(8'h64, 32'h0, "R5 zero set no change");

    pulse(1, 1, 1, 1, 1);
    rd(8'h58, 32'h364, "R2 all events latched");
    rd(8'h5C, 32'h0, "R6 masked with empty mask");
    chk_irq(0, "R7 no irq while masked off");

    wr(8'h60, 32'h300);
    rd(8'h64, 32'h300, "R5 set eof bits");
    chk_irq(1, "R7 irq on enabled pending");
    wr(8'h60, 32'h020);
    rd(8'h60, 32'h320, "R5 set keeps others");
    wr(8'h64, 32'h100);
    rd(8'h60, 32'h220, "R5 clear only written bits");
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, 32'h364, "R5 only event bits settable");
    wr(8'h64, 32'h144);
    rd(8'h5C, 32'h220, "R6 masked view");

    wr(8'h58, 32'hFFF);
    rd(8'h58, 32'h364, "R3 raw write ignored");
    chk_irq(1, "R7 irq holds while pending");

    wr(8'h5C, 32'h220);
    rd(8'h58, 32'h144, "R3 w1c clears written bits");
    chk_irq(0, "R7 irq drops when drained");

    pulse(0, 0, 0, 0, 1);
    rd(8'h5C, 32'h200, "R8 pending while disarmed");
    chk_irq(0, "R8 stays low until eoi");
    wr(8'h68, 32'h0);
    chk_irq(1, "R8 eoi re-raises pending");

    // event and clear on the same bit in one cycle
    @(negedge clk);
    valid = 1; write = 1; addr = 8'h5C; wdata = 32'h200; ev_eof1 = 1;
    @(negedge clk);
    valid = 0; write = 0; ev_eof1 = 0;
    rd(8'h58, 32'h344, "R4 event wins over clear");

    wr(8'h5C, 32'hFFFF_FFFF);
    rd(8'h58, 32'h0, "R3 clear all");
    chk_irq(0, "R7 low after clear all");
    wr(8'h68, 32'h1234);
    chk_irq(0, "R8 eoi with nothing pending");
    pulse(0, 1, 0, 0, 0);
    chk_irq(1, "R8 rearmed line fires on new event");

    wr(8'h6C, 32'hFFFF_FFFF);
    check({29'b0, clk_en}, 32'h7, "R10 clk_en all");
    rd(8'h6C, 32'h7, "R10 clk read upper zero");
    wr(8'h6C, 32'h5);
    check({29'b0, clk_en}, 32'h5, "R10 clk_en pattern");

    wr(8'h00, 32'h0);
    rd(8'h00, 32'h4F20_0800, "R9 id write ignored");
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, 32'h0, "R11 undefined reads zero");
    rd(8'h70, 32'h0, "R11 unlisted offset zero");
    rd(8'h60, 32'h220, "R11 undefined write no effect");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check(32'(exp_q.size()), 32'h0, "R11 reads left unanswered");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R11: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule